// File: doc/BRIEF.md
# Sixteen-Operation Flag-Setting ALU

This block is the integer execution datapath of a small processor core. Each cycle it takes a 4-bit operation code, a destination operand, a source operand and the current condition flags. From these it forms a 32-bit result, a write-back enable and a new set of negative, zero, carry and overflow flags. The operations cover bitwise logic, shifts and a rotate whose amount comes from a register, add and subtract with carry, negate, three flag-only comparisons, and a multiply that keeps the low word.

Every subtraction uses the same adder as addition. The adder adds the inverted source operand and a carry-in, so the carry flag after a subtraction means "no borrow". The outputs can be registered, which gives one cycle of latency, or left combinational. The register file and the operand selection live outside the block.

Top module: `flag_alu`

## Requirements
- R1: The operation codes select these functions: 0 A AND B, 1 A XOR B, 2 shift left, 3 logical shift right, 4 arithmetic shift right, 5 add with carry, 6 subtract with carry, 7 rotate right, 8 test (AND), 9 negate, 10 compare, 11 compare-negative, 12 A OR B, 13 multiply, 14 A AND NOT B, 15 NOT B. The flags vector is {N, Z, C, V}, with N at bit 3.
- R2: Codes 8, 10 and 11 drive the write enable low and still update the flags. Every other code drives the write enable high.
- R3: Add with carry returns A + B + C. C becomes the carry out of bit 31.
- R4: Subtract with carry returns A + NOT B + C. C becomes the carry out, which is 1 when no borrow occurs.
- R5: Negate returns 0 + NOT B + 1. C and V follow the adder.
- R6: Compare sets the flags of A + NOT B + 1. Compare-negative sets the flags of A + B + 0.
- R7: All arithmetic codes (5, 6, 9, 10, 11) set V when the result has signed overflow, and set N and Z from the sum.
- R8: The logic codes (0, 1, 8, 12, 14, 15) set N from result bit 31 and Z when the result is zero. They leave C and V unchanged.
- R9: A shift or rotate uses only bits 7:0 of B as the amount. An amount of 0 returns A unchanged and keeps C. Shifts set N and Z from the result and always keep V.
- R10: A left or logical right shift by 1 to 31 sets C to the last bit shifted out. By exactly 32 the result is 0 and C is bit 0 (left) or bit 31 (right). Above 32 both the result and C are 0.
- R11: An arithmetic right shift by 32 or more fills all bits with A[31], and C equals A[31].
- R12: A rotate by a nonzero amount that is a multiple of 32 returns A unchanged with C = A[31]. Any other nonzero amount rotates by amount mod 32, and C becomes the new bit 31.
- R13: Multiply returns the low 32 bits of A times B. It sets N and Z and leaves C and V unchanged.
- R14: With registered outputs, the result, write enable and flags appear on the clock edge after the inputs. A synchronous reset clears all of them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | Destination operand |
| opnd_b | input | 32 | Source operand, also the shift amount |
| flags_in | input | 4 | Current {N, Z, C, V} |
| res_out | output | 32 | Operation result |
| res_we | output | 1 | Result write-back enable |
| flags_out | output | 4 | Updated {N, Z, C, V} |

## Verification
The hardest cases to reach are the shifter's edge amounts. Amounts of exactly 32, amounts above 32 whose low five bits are zero, and register values whose upper bytes are nonzero while bits 7:0 are zero all change the carry in ways an ordinary small amount never shows. The stimulus places these exact values in the B operand, and sets C and V beforehand so that any kept or changed flag is visible. The arithmetic overflow boundaries are reached with the operand pairs 0x7FFFFFFF + 1, 0x80000000 - 1 and the negation of 0x80000000.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_XOR  = 4'd1,
        OP_SHL  = 4'd2,
        OP_SHR  = 4'd3,
        OP_SAR  = 4'd4,
        OP_ADC  = 4'd5,
        OP_SBC  = 4'd6,
        OP_ROR  = 4'd7,
        OP_TST  = 4'd8,
        OP_NEG  = 4'd9,
        OP_CMP  = 4'd10,
        OP_CMN  = 4'd11,
        OP_ORR  = 4'd12,
        OP_MUL  = 4'd13,
        OP_BIC  = 4'd14,
        OP_NOTB = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2,
        SH_ROT   = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        FC_LOGIC = 2'd0,
        FC_SHIFT = 2'd1,
        FC_ARITH = 2'd2,
        FC_MUL   = 2'd3
    } flag_class_e;

    function automatic logic op_writes(alu_op_e op);
        return !(op == OP_TST || op == OP_CMP || op == OP_CMN);
    endfunction

    function automatic flag_class_e op_class(alu_op_e op);
        case (op)
            OP_SHL, OP_SHR, OP_SAR, OP_ROR:         return FC_SHIFT;
            OP_ADC, OP_SBC, OP_NEG, OP_CMP, OP_CMN: return FC_ARITH;
            OP_MUL:                                 return FC_MUL;
            default:                                return FC_LOGIC;
        endcase
    endfunction

    function automatic shift_kind_e op_shift(alu_op_e op);
        case (op)
            OP_SHL:  return SH_LEFT;
            OP_SHR:  return SH_RIGHT;
            OP_SAR:  return SH_ARITH;
            default: return SH_ROT;
        endcase
    endfunction

endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
        // signed overflow: same-sign inputs, different-sign sum
        ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/flag_alu_shifter.sv
module flag_alu_shifter
    import flag_alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  shift_kind_e   kind,
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    input  logic          cin,
    output logic [W-1:0]  res,
    output logic          cout
);
    localparam int SW = $clog2(W);

    logic [W:0]      ext_l;
    logic [W:0]      ext_r;
    logic [W:0]      ext_a;
    logic [2*W-1:0]  rot;
    logic [AW-1:0]   amt_sat;
    logic [SW-1:0]   rot_amt;

    always_comb begin
        amt_sat = (amt > AW'(W)) ? AW'(W) : amt;
        rot_amt = amt[SW-1:0];
        // one spare bit catches the last bit shifted out
        ext_l   = {1'b0, val} << amt;
        ext_r   = {val, 1'b0} >> amt;
        ext_a   = $unsigned($signed({val, 1'b0}) >>> amt_sat);
        rot     = {val, val} >> rot_amt;

        res  = val;
        cout = cin;
        if (amt != '0) begin
            case (kind)
                SH_LEFT: begin
                    res  = ext_l[W-1:0];
                    cout = ext_l[W];
                end
                SH_RIGHT: begin
                    res  = ext_r[W:1];
                    cout = ext_r[0];
                end
                SH_ARITH: begin
                    res  = ext_a[W:1];
                    cout = ext_a[0];
                end
                default: begin
                    res  = rot[W-1:0];
                    cout = rot[W-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_XOR:  res = a ^ b;
            OP_ORR:  res = a | b;
            OP_BIC:  res = a & ~b;
            OP_NOTB: res = ~b;
            default: res = a & b;
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W       = 32,
    parameter int AW      = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [3:0]   flags_in,
    output logic [W-1:0] res_out,
    output logic         res_we,
    output logic [3:0]   flags_out
);
    alu_op_e     op;
    flags_t      fin;
    flag_class_e fclass;

    assign op     = alu_op_e'(op_code);
    assign fin    = flags_t'(flags_in);
    assign fclass = op_class(op);

    // adder operand steering: subtraction is A + ~B + carry-in
    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;

    always_comb begin
        add_x   = opnd_a;
        add_y   = opnd_b;
        add_cin = 1'b0;
        case (op)
            OP_ADC: add_cin = fin.c;
            OP_SBC: begin add_y = ~opnd_b; add_cin = fin.c; end
            OP_NEG: begin add_x = '0; add_y = ~opnd_b; add_cin = 1'b1; end
            OP_CMP: begin add_y = ~opnd_b; add_cin = 1'b1; end
            default: ;
        endcase
    end

    flag_alu_adder #(.W(W)) u_add (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    logic [W-1:0] sh_res;
    logic         sh_cout;

    flag_alu_shifter #(.W(W), .AW(AW)) u_sh (
        .kind (op_shift(op)),
        .val  (opnd_a),
        .amt  (opnd_b[AW-1:0]),
        .cin  (fin.c),
        .res  (sh_res),
        .cout (sh_cout)
    );

    logic [W-1:0] lg_res;

    flag_alu_logic #(.W(W)) u_lg (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (lg_res)
    );

    logic [W-1:0] mul_res;
    assign mul_res = opnd_a * opnd_b;

    logic [W-1:0] nx_res;
    logic         nx_we;
    flags_t       nx_flags;

    always_comb begin
        nx_flags = fin;
        case (fclass)
            FC_SHIFT: begin
                nx_res     = sh_res;
                nx_flags.c = sh_cout;
            end
            FC_ARITH: begin
                nx_res     = add_sum;
                nx_flags.c = add_cout;
                nx_flags.v = add_ovf;
            end
            FC_MUL:   nx_res = mul_res;
            default:  nx_res = lg_res;
        endcase
        nx_flags.n = nx_res[W-1];
        nx_flags.z = (nx_res == '0);
        nx_we      = op_writes(op);
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_out   <= '0;
                    res_we    <= 1'b0;
                    flags_out <= '0;
                end else begin
                    res_out   <= nx_res;
                    res_we    <= nx_we;
                    flags_out <= nx_flags;
                end
            end
        end else begin : g_comb
            assign res_out   = nx_res;
            assign res_we    = nx_we;
            assign flags_out = nx_flags;
        end
    endgenerate
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int W       = 32,
    parameter int AW      = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   op_code,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [3:0]   flags_in,
    input logic [W-1:0] res_out,
    input logic         res_we,
    input logic [3:0]   flags_out
);
    logic flag_only;
    logic is_logic;
    logic is_shift;
    assign flag_only = (op_code == 4'd8) || (op_code == 4'd10) || (op_code == 4'd11);
    assign is_logic  = (op_code == 4'd0) || (op_code == 4'd1) || (op_code == 4'd8) ||
                       (op_code == 4'd12) || (op_code == 4'd14) || (op_code == 4'd15);
    assign is_shift  = (op_code == 4'd2) || (op_code == 4'd3) ||
                       (op_code == 4'd4) || (op_code == 4'd7);

    generate
        if (REG_OUT) begin : g_props
            // R2: flag-only codes never write back
            p_no_write_r2: assert property (@(posedge clk) disable iff (rst)
                flag_only |=> !res_we);
            // R2: all other codes write back
            p_write_r2: assert property (@(posedge clk) disable iff (rst)
                !flag_only |=> res_we);
            // R8: logic codes keep C and V
            p_keep_cv_r8: assert property (@(posedge clk) disable iff (rst)
                is_logic |=> flags_out[1:0] == $past(flags_in[1:0]));
            // R9: shifts keep V
            p_shift_keep_v_r9: assert property (@(posedge clk) disable iff (rst)
                is_shift |=> flags_out[0] == $past(flags_in[0]));
            // R9: zero amount leaves value and carry untouched
            p_zero_amt_r9: assert property (@(posedge clk) disable iff (rst)
                (is_shift && opnd_b[AW-1:0] == '0) |=>
                (res_out == $past(opnd_a)) && (flags_out[1] == $past(flags_in[1])));
            // R13: multiply keeps C and V
            p_mul_cv_r13: assert property (@(posedge clk) disable iff (rst)
                (op_code == 4'd13) |=> flags_out[1:0] == $past(flags_in[1:0]));
            // R8: written results agree with the N and Z flags
            p_nz_match_r8: assert property (@(posedge clk) disable iff (rst)
                res_we |-> (flags_out[3] == res_out[W-1]) &&
                           (flags_out[2] == (res_out == '0)));
        end
    endgenerate
endmodule

bind flag_alu flag_alu_chk #(.W(W), .AW(AW), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .flags_in  (flags_in),
    .res_out   (res_out),
    .res_we    (res_we),
    .flags_out (flags_out)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  flags_in = '0;
    logic [31:0] res_out;
    logic        res_we;
    logic [3:0]  flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flag_alu u0 (
        .clk       (clk),
        .rst       (rst),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .flags_in  (flags_in),
        .res_out   (res_out),
        .res_we    (res_we),
        .flags_out (flags_out)
    );

    task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one operation, sample on the following falling edge
    task automatic run(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic [3:0] fin, bit chk_res, logic [31:0] exp_res,
                       logic exp_we, logic [3:0] exp_fl);
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; flags_in = fin;
        @(negedge clk);
        if (chk_res) expect_eq({tag, " result"}, res_out, exp_res);
        expect_eq({tag, " we"}, {31'd0, res_we}, {31'd0, exp_we});
        expect_eq({tag, " flags"}, {28'd0, flags_out}, {28'd0, exp_fl});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        expect_eq("R14 reset result", res_out, 32'h0);
        expect_eq("R14 reset we", {31'd0, res_we}, 32'h0);
        expect_eq("R14 reset flags", {28'd0, flags_out}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_logic();
        run("R1 R8 and",  4'd0,  32'hF0F0_00FF, 32'h0FF0_0F0F, 4'b0011, 1, 32'h00F0_000F, 1, 4'b0011);
        run("R1 xor",     4'd1,  32'hFFFF_0000, 32'hFFFF_FFFF, 4'b0000, 1, 32'h0000_FFFF, 1, 4'b0000);
        run("R1 R8 orr",  4'd12, 32'h8000_0000, 32'h0000_0001, 4'b0010, 1, 32'h8000_0001, 1, 4'b1010);
        run("R1 R8 bic",  4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0001, 1, 32'h0,         1, 4'b0101);
        run("R1 notb",    4'd15, 32'h1234_5678, 32'h0,         4'b0000, 1, 32'hFFFF_FFFF, 1, 4'b1000);
    endtask

    task automatic t_flag_only();
        run("R2 tst",       4'd8,  32'h0F,        32'hF0, 4'b0010, 0, 32'h0, 0, 4'b0110);
        run("R2 R6 cmp eq", 4'd10, 32'h5,         32'h5, 4'b0000, 0, 32'h0, 0, 4'b0110);
        run("R6 cmp lt",    4'd10, 32'h3,         32'h5, 4'b0010, 0, 32'h0, 0, 4'b1000);
        run("R2 R6 cmn",    4'd11, 32'hFFFF_FFFF, 32'h1, 4'b0000, 0, 32'h0, 0, 4'b0110);
    endtask

    task automatic t_arith();
        run("R3 adc c1",   4'd5, 32'h1,         32'h2, 4'b0010, 1, 32'h4,         1, 4'b0000);
        run("R3 adc wrap", 4'd5, 32'hFFFF_FFFF, 32'h0, 4'b0010, 1, 32'h0,         1, 4'b0110);
        run("R7 adc ovf",  4'd5, 32'h7FFF_FFFF, 32'h1, 4'b0000, 1, 32'h8000_0000, 1, 4'b1001);
        run("R4 sbc c1",   4'd6, 32'd10,        32'd3, 4'b0010, 1, 32'd7,         1, 4'b0010);
        run("R4 sbc c0",   4'd6, 32'd10,        32'd3, 4'b0000, 1, 32'd6,         1, 4'b0010);
        run("R4 sbc brw",  4'd6, 32'h0,         32'h0, 4'b0000, 1, 32'hFFFF_FFFF, 1, 4'b1000);
        run("R7 sbc ovf",  4'd6, 32'h8000_0000, 32'h1, 4'b0010, 1, 32'h7FFF_FFFF, 1, 4'b0011);
        run("R5 neg 1",    4'd9, 32'h55,        32'h1, 4'b0000, 1, 32'hFFFF_FFFF, 1, 4'b1000);
        run("R5 neg 0",    4'd9, 32'h55,        32'h0, 4'b0000, 1, 32'h0,         1, 4'b0110);
        run("R5 R7 neg min", 4'd9, 32'h0,  32'h8000_0000, 4'b0000, 1, 32'h8000_0000, 1, 4'b1001);
    endtask

    task automatic t_shift();
        run("R10 shl 1",    4'd2, 32'h8000_0001, 32'd1,  4'b0000, 1, 32'h2, 1, 4'b0010);
        run("R10 shl 32",   4'd2, 32'h0000_0001, 32'd32, 4'b0001, 1, 32'h0, 1, 4'b0111);
        run("R10 shl 33",   4'd2, 32'hFFFF_FFFF, 32'd33, 4'b0010, 1, 32'h0, 1, 4'b0100);
        run("R10 shr 4",    4'd3, 32'h0000_000F, 32'd4,  4'b0000, 1, 32'h0, 1, 4'b0110);
        run("R10 shr 32",   4'd3, 32'h8000_0000, 32'd32, 4'b0000, 1, 32'h0, 1, 4'b0110);
        run("R10 shr 40",   4'd3, 32'hFFFF_FFFF, 32'd40, 4'b0010, 1, 32'h0, 1, 4'b0100);
        run("R9 amt 0x100", 4'd2, 32'h1234_5678, 32'h100, 4'b0011, 1, 32'h1234_5678, 1, 4'b0011);
        run("R9 amt 0x104", 4'd3, 32'h0000_00F0, 32'h104, 4'b0010, 1, 32'h0000_000F, 1, 4'b0000);
        run("R11 sar 4",    4'd4, 32'h8000_0010, 32'd4,   4'b0000, 1, 32'hF800_0001, 1, 4'b1000);
        run("R11 sar 200",  4'd4, 32'h8000_0000, 32'd200, 4'b0001, 1, 32'hFFFF_FFFF, 1, 4'b1011);
        run("R11 sar 32",   4'd4, 32'h4000_0000, 32'd32,  4'b0010, 1, 32'h0,         1, 4'b0100);
        run("R12 ror 1",    4'd7, 32'h0000_0001, 32'd1,   4'b0000, 1, 32'h8000_0000, 1, 4'b1010);
        run("R12 ror 64",   4'd7, 32'h8000_0000, 32'd64,  4'b0000, 1, 32'h8000_0000, 1, 4'b1010);
        run("R12 ror 8",    4'd7, 32'h1234_5678, 32'd8,   4'b0010, 1, 32'h7812_3456, 1, 4'b0000);
        run("R9 ror 0",     4'd7, 32'h0000_0040, 32'd0,   4'b0010, 1, 32'h0000_0040, 1, 4'b0010);
    endtask

    task automatic t_mul();
        run("R13 mul",      4'd13, 32'd3,         32'd5,     4'b0011, 1, 32'd15,        1, 4'b0011);
        run("R13 mul wrap", 4'd13, 32'h0001_0000, 32'h1_0000, 4'b0001, 1, 32'h0,        1, 4'b0101);
        run("R13 mul neg",  4'd13, 32'hFFFF_FFFF, 32'd2,     4'b0000, 1, 32'hFFFF_FFFE, 1, 4'b1000);
    endtask

    task automatic t_latency_reset();
        run("R14 setup", 4'd12, 32'hA5, 32'h0, 4'b0000, 1, 32'hA5, 1, 4'b0000);
        @(negedge clk);
        op_code = 4'd5; opnd_a = 32'h100; opnd_b = 32'h1; flags_in = 4'b0000;
        #1;
        expect_eq("R14 held before edge", res_out, 32'hA5);
        @(negedge clk);
        expect_eq("R14 after edge", res_out, 32'h101);
        rst = 1'b1;
        @(negedge clk);
        expect_eq("R14 sync reset result", res_out, 32'h0);
        expect_eq("R14 sync reset we", {31'd0, res_we}, 32'h0);
        expect_eq("R14 sync reset flags", {28'd0, flags_out}, 32'h0);
        rst = 1'b0;
    endtask

    initial begin
        t_reset();
        t_logic();
        t_flag_only();
        t_arith();
        t_shift();
        t_mul();
        t_latency_reset();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule